// File: doc/BRIEF.md
# Pixel Triple Parallel-Port Link

This block sits between a small processor and two external sides: a host on an enhanced parallel port and a capture memory filled by a video sampler. One interrupt from the host fetches a whole pixel. The host opens each pixel with a data-strobe cycle. This raises one processor interrupt and fetches the red byte. Two further address-strobe cycles fetch green and blue without any interrupt. Each host cycle holds the WAIT line high until the processor has written the next byte into the output latch and the host has dropped its strobe.

On the processor side, two port addresses are decoded from a bus address. The output port carries byte writes toward the host. The input port enables a buffer that drives sampler data onto the processor read bus. Every read of the input port also pulses the capture memory address counter once, at the start of the read. The host strobes are asynchronous and pass through `SYNC_STAGES` flip-flops before use.

The write path toward the host is valid/ready. `cpu_wr_ready` is high only while a host cycle has been accepted and is waiting for its byte. A write offered at any other time stalls and is not taken.

Top module: `epp_pix_link`

## Requirements
- R1: After reset, `host_wait`, `cpu_irq`, `host_le` and `cpu_wr_ready` are low, `host_data` is 0, and `rgb_pos` is 2 (blue, triple complete).
- R2: A rising edge on `host_dstb` while `host_wait` is low raises `host_wait`, sets `rgb_pos` to 0 (red), and produces exactly one single-cycle `cpu_irq` pulse.
- R3: A rising edge on `host_astb` while `host_wait` is low, with `rgb_pos` below 2, raises `host_wait` and advances `rgb_pos` by one (0 red, 1 green, 2 blue), with no `cpu_irq`. When `rgb_pos` is 2, an address-strobe edge is ignored: `host_wait` stays low and there is no interrupt.
- R4: While a host cycle waits for its byte, `cpu_wr_ready` is high. A write with `cpu_wr_valid` to the output port copies `cpu_wdata` to `host_data`, pulses `host_le` for one cycle and drops `cpu_wr_ready`. `host_wait` stays high until the host releases the strobe that opened the cycle, and then returns low.
- R5: The output port is at address `PORT_BASE`+0 and the input port is at `PORT_BASE`+1. A write to any other address is never accepted and leaves `host_le` and `host_data` unchanged.
- R6: While `cpu_rd` is high at the input port address, `smp_oe` is high and `cpu_rdata` equals `smp_data`. Otherwise `smp_oe` is low and `cpu_rdata` is 0. `cap_advance` pulses for exactly one cycle at the start of each such read.
- R7: A strobe edge that arrives while `host_wait` is high is held, not lost. It is served as soon as `host_wait` returns low.
- R8: A write offered to the output port while no host cycle is open is stalled: `cpu_wr_ready` stays low, and there is no `host_le` and no change to `host_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | AW | Processor port address |
| cpu_wr_valid | input | 1 | Processor offers a write |
| cpu_wr_ready | output | 1 | Output latch can take a byte |
| cpu_wdata | input | DW | Byte written toward the host |
| cpu_rd | input | 1 | Processor read enable |
| cpu_rdata | output | DW | Read data toward the processor |
| smp_oe | output | 1 | Enable for the sampler-to-processor buffer |
| smp_data | input | DW | Sampler data bus |
| cap_advance | output | 1 | One-cycle pulse that steps the capture address counter |
| host_dstb | input | 1 | Host data strobe, active high, asynchronous |
| host_astb | input | 1 | Host address strobe, active high, asynchronous |
| host_wait | output | 1 | Handshake back to the host |
| host_data | output | DW | Output latch toward the host |
| host_le | output | 1 | One-cycle latch-enable pulse |
| cpu_irq | output | 1 | One-cycle interrupt per pixel request |
| rgb_pos | output | 2 | Colour position of the current byte |

## Verification
The bench replays whole pixel transfers. One of them runs a fourth address strobe past blue: a design that counted past blue or raised WAIT for that strobe would hang the host or misalign later colours. A second strobe is raised while the first cycle still holds WAIT. A design that dropped that edge would leave the host waiting for ever, and one that served it early would drive WAIT low too soon. Writes are offered while no cycle is open and to a neighbouring address. A design that accepted either would drive a stale or wrong byte. Long reads check that the capture counter steps once per read and not once per cycle.

// File: rtl/epp_pix_pkg.sv
`timescale 1ns/1ps
package epp_pix_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_SERVE} link_st_e;
  typedef enum logic {K_DATA, K_ADDR} stb_kind_e;
  localparam logic [1:0] POS_RED   = 2'd0;
  localparam logic [1:0] POS_GREEN = 2'd1;
  localparam logic [1:0] POS_BLUE  = 2'd2;
endpackage

// File: rtl/epp_addr_dec.sv
`timescale 1ns/1ps
module epp_addr_dec #(
  parameter int AW = 8,
  parameter int DEC_W = 3,
  parameter int NUM_SEL = 2,
  parameter logic [AW-1:0] BASE = 8'h30
) (
  input  logic [AW-1:0]      addr,
  output logic [NUM_SEL-1:0] sel
);
  localparam logic [AW-DEC_W-1:0] BASE_HI = BASE[AW-1:DEC_W];

  logic hi_match;
  assign hi_match = (addr[AW-1:DEC_W] == BASE_HI);

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    assign sel[i] = hi_match && (addr[DEC_W-1:0] == DEC_W'(i));
  end
endmodule

// File: rtl/epp_stb_sync.sv
`timescale 1ns/1ps
module epp_stb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_in,
  output logic level,
  output logic rise
);
  logic [STAGES:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-1:0], stb_in};
  end

  assign level = sr[STAGES-1];
  assign rise  = sr[STAGES-1] & ~sr[STAGES];
endmodule

// File: rtl/epp_pix_fsm.sv
`timescale 1ns/1ps
module epp_pix_fsm
  import epp_pix_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          d_rise,
  input  logic          a_rise,
  input  logic          d_lvl,
  input  logic          a_lvl,
  input  logic          wr_hit,
  input  logic [DW-1:0] wdata,
  output logic          wr_ready,
  output logic          host_wait,
  output logic [DW-1:0] host_data,
  output logic          host_le,
  output logic          irq,
  output logic [1:0]    rgb_pos
);
  link_st_e  st;
  stb_kind_e cur_k, pend_k, start_k;
  logic      pend_v, start_v, start_take, start_new_d, start_new_a;

  // choose what to start in IDLE: held edge first, then fresh edges
  always_comb begin
    start_v     = (st == ST_IDLE) && (pend_v || d_rise || a_rise);
    start_new_d = (st == ST_IDLE) && !pend_v && d_rise;
    start_new_a = (st == ST_IDLE) && !pend_v && !d_rise && a_rise;
    if (pend_v)      start_k = pend_k;
    else if (d_rise) start_k = K_DATA;
    else             start_k = K_ADDR;
    start_take = start_v && !(start_k == K_ADDR && rgb_pos == POS_BLUE);
  end

  assign wr_ready  = (st == ST_FETCH);
  assign host_wait = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_k     <= K_DATA;
      pend_v    <= 1'b0;
      pend_k    <= K_DATA;
      host_data <= '0;
      host_le   <= 1'b0;
      irq       <= 1'b0;
      rgb_pos   <= POS_BLUE;
    end else begin
      host_le <= 1'b0;
      irq     <= 1'b0;
      // pending edge bookkeeping
      if (start_v && pend_v) pend_v <= 1'b0;
      if (d_rise && !start_new_d) begin
        pend_v <= 1'b1;
        pend_k <= K_DATA;
      end else if (a_rise && !start_new_a) begin
        pend_v <= 1'b1;
        pend_k <= K_ADDR;
      end
      unique case (st)
        ST_IDLE: if (start_take) begin
          st    <= ST_FETCH;
          cur_k <= start_k;
          if (start_k == K_DATA) begin
            rgb_pos <= POS_RED;
            irq     <= 1'b1;
          end else begin
            rgb_pos <= rgb_pos + 2'd1;
          end
        end
        ST_FETCH: if (wr_hit) begin
          host_data <= wdata;
          host_le   <= 1'b1;
          st        <= ST_SERVE;
        end
        ST_SERVE: if ((cur_k == K_DATA) ? !d_lvl : !a_lvl) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_IRQ_OPENS_RED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rgb_pos == POS_RED && host_wait)); // R2
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rgb_pos != 2'd3); // R3
  AST_LE_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    host_le |-> (host_wait && !wr_ready)); // R4
  AST_READY_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> host_wait); // R8
  AST_HELD_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rise && host_wait) |=> pend_v); // R7
endmodule

// File: rtl/epp_pix_link.sv
`timescale 1ns/1ps
module epp_pix_link
  import epp_pix_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int DEC_W = 3,
  parameter logic [AW-1:0] PORT_BASE = 8'h30,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_wr_valid,
  output logic          cpu_wr_ready,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rd,
  output logic [DW-1:0] cpu_rdata,
  output logic          smp_oe,
  input  logic [DW-1:0] smp_data,
  output logic          cap_advance,
  input  logic          host_dstb,
  input  logic          host_astb,
  output logic          host_wait,
  output logic [DW-1:0] host_data,
  output logic          host_le,
  output logic          cpu_irq,
  output logic [1:0]    rgb_pos
);
  localparam int SEL_OUT = 0;
  localparam int SEL_IN  = 1;

  logic [1:0] sel;
  logic d_lvl, d_rise, a_lvl, a_rise;
  logic rd_hit, rd_hit_q;

  epp_addr_dec #(.AW(AW), .DEC_W(DEC_W), .NUM_SEL(2), .BASE(PORT_BASE)) u_dec (
    .addr(cpu_addr), .sel(sel));

  epp_stb_sync #(.STAGES(SYNC_STAGES)) u_sync_d (
    .clk(clk), .rst_n(rst_n), .stb_in(host_dstb), .level(d_lvl), .rise(d_rise));
  epp_stb_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst_n(rst_n), .stb_in(host_astb), .level(a_lvl), .rise(a_rise));

  epp_pix_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .d_rise(d_rise), .a_rise(a_rise), .d_lvl(d_lvl), .a_lvl(a_lvl),
    .wr_hit(cpu_wr_valid && sel[SEL_OUT]), .wdata(cpu_wdata),
    .wr_ready(cpu_wr_ready), .host_wait(host_wait), .host_data(host_data),
    .host_le(host_le), .irq(cpu_irq), .rgb_pos(rgb_pos));

  // read path from the sampler bus
  assign rd_hit    = cpu_rd && sel[SEL_IN];
  assign smp_oe    = rd_hit;
  assign cpu_rdata = rd_hit ? smp_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_hit_q <= 1'b0;
    else        rd_hit_q <= rd_hit;
  end
  assign cap_advance = rd_hit && !rd_hit_q;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R5
  AST_ADV_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_advance |=> !cap_advance); // R6
  AST_LE_ONLY_OUT_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    host_le |-> ($past(cpu_wr_valid) && $past(cpu_addr) == PORT_BASE)); // R5
endmodule

// File: tb/tb_epp_pix_link.sv
`timescale 1ns/1ps
module tb_epp_pix_link;
  localparam logic [7:0] BASE = 8'h30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cpu_addr = '0, cpu_wdata = '0, smp_data = '0;
  logic cpu_wr_valid = 1'b0, cpu_rd = 1'b0, host_dstb = 1'b0, host_astb = 1'b0;
  logic cpu_wr_ready, smp_oe, cap_advance, host_wait, host_le, cpu_irq;
  logic [7:0] cpu_rdata, host_data;
  logic [1:0] rgb_pos;

  int n_chk = 0, n_fail = 0, irq_cnt = 0, le_cnt = 0, adv_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  epp_pix_link dut (.*);

  always @(posedge clk) begin
    if (cpu_irq) irq_cnt++;
    if (host_le) le_cnt++;
    if (cap_advance) adv_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_write(input logic [7:0] a, input logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr_valid = 1'b1;
    cyc(1);
    cpu_wr_valid = 1'b0;
    cyc(2);
  endtask

  // vector: kind(1: address strobe) data(8) irq_delta(1) pos(2) served(1)
  localparam int NV = 9;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 8'h11, 1'b1, 2'd0, 1'b1},
    {1'b1, 8'h22, 1'b0, 2'd1, 1'b1},
    {1'b1, 8'h33, 1'b0, 2'd2, 1'b1},
    {1'b1, 8'h44, 1'b0, 2'd2, 1'b0},
    {1'b0, 8'h55, 1'b1, 2'd0, 1'b1},
    {1'b1, 8'h66, 1'b0, 2'd1, 1'b1},
    {1'b0, 8'h77, 1'b1, 2'd0, 1'b1},
    {1'b1, 8'h88, 1'b0, 2'd1, 1'b1},
    {1'b1, 8'h99, 1'b0, 2'd2, 1'b1}
  };

  initial begin
    int irq0, le0;
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    eq("R1 wait", host_wait, 0);
    eq("R1 irq", cpu_irq, 0);
    eq("R1 le", host_le, 0);
    eq("R1 ready", cpu_wr_ready, 0);
    eq("R1 data", host_data, 0);
    eq("R1 pos", rgb_pos, 2);

    // R8 write while no cycle open
    le0 = le_cnt;
    cpu_addr = BASE; cpu_wdata = 8'hEE; cpu_wr_valid = 1'b1;
    cyc(1);
    eq("R8 ready", cpu_wr_ready, 0);
    cyc(2);
    cpu_wr_valid = 1'b0;
    cyc(1);
    eq("R8 le", le_cnt - le0, 0);
    eq("R8 data", host_data, 0);

    // pixel transfer table (R2 R3 R4)
    for (int i = 0; i < NV; i++) begin
      logic kind, ex_irq, served;
      logic [7:0] d;
      logic [1:0] ex_pos;
      {kind, d, ex_irq, ex_pos, served} = VEC[i];
      irq0 = irq_cnt; le0 = le_cnt;
      if (kind) host_astb = 1'b1; else host_dstb = 1'b1;
      cyc(6);
      eq(kind ? "R3 irq" : "R2 irq", irq_cnt - irq0, int'(ex_irq));
      eq(kind ? "R3 pos" : "R2 pos", rgb_pos, ex_pos);
      eq(kind ? "R3 wait" : "R2 wait", host_wait, int'(served));
      if (served) begin
        eq("R4 ready", cpu_wr_ready, 1);
        cpu_write(BASE, d);
        eq("R4 le", le_cnt - le0, 1);
        eq("R4 data", host_data, d);
        eq("R4 ready low", cpu_wr_ready, 0);
        eq("R4 wait held", host_wait, 1);
      end
      host_dstb = 1'b0; host_astb = 1'b0;
      cyc(6);
      eq("R4 wait released", host_wait, 0);
    end

    // R7 held strobe, with R5 wrong-address write
    irq0 = irq_cnt;
    host_dstb = 1'b1;
    cyc(6);
    cpu_write(BASE, 8'hA1);
    host_astb = 1'b1;
    cyc(6);
    eq("R7 wait still high", host_wait, 1);
    eq("R7 pos not yet", rgb_pos, 0);
    host_dstb = 1'b0;
    cyc(8);
    eq("R7 served wait", host_wait, 1);
    eq("R7 served pos", rgb_pos, 1);
    eq("R7 irq", irq_cnt - irq0, 1);
    le0 = le_cnt;
    cpu_addr = BASE + 8'd2; cpu_wdata = 8'hC3; cpu_wr_valid = 1'b1;
    cyc(3);
    cpu_wr_valid = 1'b0;
    cyc(2);
    eq("R5 no le", le_cnt - le0, 0);
    eq("R5 data kept", host_data, 8'hA1);
    eq("R5 ready kept", cpu_wr_ready, 1);
    cpu_write(BASE, 8'hB2);
    eq("R7 data", host_data, 8'hB2);
    host_astb = 1'b0;
    cyc(6);
    eq("R7 wait low", host_wait, 0);

    // R6 reads
    le0 = adv_cnt;
    smp_data = 8'h5A; cpu_addr = BASE + 8'd1; cpu_rd = 1'b1;
    cyc(1);
    eq("R6 oe", smp_oe, 1);
    eq("R6 rdata", cpu_rdata, 8'h5A);
    cyc(4);
    cpu_rd = 1'b0;
    cyc(2);
    eq("R6 one advance", adv_cnt - le0, 1);
    eq("R6 oe off", smp_oe, 0);
    eq("R6 rdata off", cpu_rdata, 0);
    cpu_rd = 1'b1;
    cyc(2);
    cpu_rd = 1'b0;
    cyc(2);
    eq("R6 second advance", adv_cnt - le0, 2);
    cpu_addr = BASE; cpu_rd = 1'b1;
    cyc(1);
    eq("R5 out addr no oe", smp_oe, 0);
    eq("R5 out addr rdata", cpu_rdata, 0);
    cpu_rd = 1'b0;
    cyc(2);
    eq("R5 no advance", adv_cnt - le0, 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule